// File: doc/BRIEF.md
# Dual-Field BCH Syndrome Calculator

This block computes the syndromes of an outer BCH codeword while the codeword streams in. It takes either one code bit per accepted beat or eight code bits per accepted beat, framed by start, end and valid qualifiers. A frame-type input selects the arithmetic. Long frames are evaluated over GF(2^16) and short frames over GF(2^14). A rate index names the expected codeword length.

For a code that corrects twelve errors, the twelve odd syndromes are accumulated by Horner steps as data arrives. After the end beat, a squaring pass fills in the even syndromes, one per clock. All twenty-four values are then presented together. A done level, an all-zero flag and a length-match flag are held until the next frame starts.

A controller with four states sequences the work. ST_IDLE waits for a start. ST_COLLECT accumulates beats. ST_SQUARE derives the even syndromes. ST_HOLD presents the results. The transitions are:
- any state to ST_COLLECT on a valid start beat without end;
- any state to ST_SQUARE on a valid start beat that also carries end;
- ST_COLLECT to ST_SQUARE on a valid end beat;
- ST_SQUARE to ST_HOLD after the twelfth squaring step.

Top module: `bchs_syndrome_calc`

## Requirements
- R1: After reset, synd_done, synd_zero and len_match are 0, and every syndrome field of synd_out is 0.
- R2: With narrow mode (wide_mode=0 at the start beat), each accepted beat contributes only in_data[0], and in_data[7:1] are ignored. The first accepted bit is the highest-degree coefficient r_{n-1}, and S_j = r(alpha^j) for j = 1..24.
- R3: With wide mode (wide_mode=1 at the start beat), each accepted beat carries eight code bits, in_data[7] being the earliest and in_data[0] the latest. The syndromes equal those of the same bit sequence fed one bit at a time.
- R4: short_frame=0 selects GF(2^16) with modulus x^16+x^5+x^3+x^2+1 (0x1002D). short_frame=1 selects GF(2^14) with modulus x^14+x^5+x^3+x+1 (0x402B). alpha is the element x, and in the short field bits 15:14 of every syndrome field are 0.
- R5: A beat with in_valid=0 is ignored even when in_start is 1. A valid beat without start is ignored in ST_IDLE and ST_HOLD.
- R6: synd_out[16*(j-1) +: 16] holds S_j for j = 1..24. Even syndromes satisfy S_2i = S_i squared. synd_done rises exactly 12 clock cycles after the edge that accepts the end beat.
- R7: synd_done, synd_zero, len_match and synd_out stay unchanged from ST_HOLD until a valid start beat, and synd_done is 0 in the cycle after that beat.
- R8: synd_zero is 1 exactly when synd_done is 1 and all 24 syndromes are 0.
- R9: len_match is 1 with synd_done when the count of accepted bits equals the length for the latched rate index (0..10) and frame type. For long frames the lengths are 16200, 21600, 25920, 32400, 38880, 43200, 48600, 51840, 54000, 57600 and 58320. For short frames they are 3240, 5400, 6480, 7200, 9720, 10800, 11880, 12600, 13320 and 14400 for indices 0..9. Short index 10 and indices above 10 never match.
- R10: A valid start beat during ST_COLLECT or ST_SQUARE discards the partial frame. The results then depend only on the new frame.
- R11: wide_mode, short_frame and rate_idx are sampled on the start beat. Changes to them later in the frame have no effect.
- R12: A single valid beat carrying both start and end forms a complete frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat qualifier |
| in_start | input | 1 | First beat of a frame |
| in_end | input | 1 | Last beat of a frame |
| in_data | input | 8 | Code bits; bit 0 only in narrow mode |
| wide_mode | input | 1 | 1: eight bits per beat, 0: one bit per beat |
| short_frame | input | 1 | 1: short frame over GF(2^14), 0: long frame over GF(2^16) |
| rate_idx | input | 4 | Code-rate index 0..10 |
| synd_out | output | 384 | S_1..S_24, 16 bits each, S_1 in the lowest field |
| synd_done | output | 1 | Results valid, held until the next start |
| synd_zero | output | 1 | All syndromes zero |
| len_match | output | 1 | Accepted bit count equals the expected length |

## Verification
The restart path and the end-of-frame path can act in the same cycle. A new start can land while the squaring pass is still writing even syndromes, or in the same beat as an end. The bench provokes the first case by sending a new start three cycles after an end beat. It provokes the second with a one-beat frame that carries start and end together. In both cases the presented syndromes are compared with values computed only from the newer frame. If the outputs held any trace of the abandoned frame or a stray squaring write, the comparison would show a mismatch.

// File: rtl/bchs_pkg.sv
package bchs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_SQUARE,
        ST_HOLD
    } bchs_state_t;

    // multiply by alpha (x) in the selected field
    function automatic logic [15:0] gf_xtime(input logic [15:0] a, input logic sh);
        logic [15:0] r;
        if (sh) begin
            r = {a[14:0], 1'b0} & 16'h3FFF;
            if (a[13]) r = r ^ 16'h002B;
        end else begin
            r = {a[14:0], 1'b0};
            if (a[15]) r = r ^ 16'h002D;
        end
        return r;
    endfunction

    function automatic logic [15:0] gf_mul(input logic [15:0] a, input logic [15:0] b,
                                           input logic sh);
        logic [15:0] r;
        r = '0;
        for (int i = 15; i >= 0; i--) begin
            r = gf_xtime(r, sh);
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [15:0] gf_pow(input int e, input logic sh);
        logic [15:0] r;
        r = 16'h0001;
        for (int i = 0; i < e; i++) r = gf_xtime(r, sh);
        return r;
    endfunction

    function automatic logic [16:0] frame_bits(input logic sh, input logic [3:0] rate);
        logic [16:0] n;
        if (!sh) begin
            case (rate)
                4'd0:    n = 17'd16200;
                4'd1:    n = 17'd21600;
                4'd2:    n = 17'd25920;
                4'd3:    n = 17'd32400;
                4'd4:    n = 17'd38880;
                4'd5:    n = 17'd43200;
                4'd6:    n = 17'd48600;
                4'd7:    n = 17'd51840;
                4'd8:    n = 17'd54000;
                4'd9:    n = 17'd57600;
                4'd10:   n = 17'd58320;
                default: n = 17'd0;
            endcase
        end else begin
            case (rate)
                4'd0:    n = 17'd3240;
                4'd1:    n = 17'd5400;
                4'd2:    n = 17'd6480;
                4'd3:    n = 17'd7200;
                4'd4:    n = 17'd9720;
                4'd5:    n = 17'd10800;
                4'd6:    n = 17'd11880;
                4'd7:    n = 17'd12600;
                4'd8:    n = 17'd13320;
                4'd9:    n = 17'd14400;
                default: n = 17'd0;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/bchs_odd_acc.sv
module bchs_odd_acc
    import bchs_pkg::*;
#(
    parameter int J     = 1,
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             first,
    input  logic             wide,
    input  logic             short_f,
    input  logic [LANES-1:0] din,
    output logic [15:0]      syn
);

    localparam logic [15:0] STEP1_N = gf_pow(J, 1'b0);
    localparam logic [15:0] STEP1_S = gf_pow(J, 1'b1);
    localparam logic [15:0] STEPW_N = gf_pow(J * LANES, 1'b0);
    localparam logic [15:0] STEPW_S = gf_pow(J * LANES, 1'b1);

    logic [15:0] lane_term [LANES];

    // lane k carries the coefficient weighted by alpha^(J*k)
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [15:0] CN = gf_pow(J * k, 1'b0);
        localparam logic [15:0] CS = gf_pow(J * k, 1'b1);
        assign lane_term[k] = din[k] ? (short_f ? CS : CN) : 16'h0000;
    end

    logic [15:0] base, contrib, nxt;

    always_comb begin
        base    = first ? 16'h0000 : syn;
        contrib = '0;
        if (wide) begin
            for (int k = 0; k < LANES; k++) contrib = contrib ^ lane_term[k];
            nxt = gf_mul(base, short_f ? STEPW_S : STEPW_N, short_f) ^ contrib;
        end else begin
            nxt = gf_mul(base, short_f ? STEP1_S : STEP1_N, short_f) ^ {15'h0000, din[0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    syn <= '0;
        else if (beat) syn <= nxt;
    end

    // R5: nothing but an accepted beat moves the accumulator
    a_r5_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !beat |=> $stable(syn));

endmodule

// File: rtl/bchs_len_track.sv
module bchs_len_track
    import bchs_pkg::*;
#(
    parameter int LANES = 8,
    parameter int CW    = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       beat,
    input  logic       first,
    input  logic       wide,
    input  logic       short_f,
    input  logic [3:0] rate,
    output logic       match
);

    logic [CW-1:0] count;
    logic [CW-1:0] inc;
    logic [16:0]   expected;

    assign inc      = wide ? CW'(LANES) : CW'(1);
    assign expected = frame_bits(short_f, rate);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (beat) count <= (first ? '0 : count) + inc;
    end

    assign match = (expected != 17'd0) && (count == CW'(expected));

    // R9: the bit counter only advances on accepted beats
    a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !beat |=> $stable(count));

endmodule

// File: rtl/bchs_ctrl.sv
module bchs_ctrl
    import bchs_pkg::*;
#(
    parameter  int T_CORR = 12,
    localparam int IW     = $clog2(T_CORR + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_start,
    input  logic          in_end,
    output logic          beat,
    output logic          first,
    output logic          sq_en,
    output logic [IW-1:0] sq_idx,
    output logic          done
);

    bchs_state_t state, nxt_state;

    always_comb begin
        nxt_state = state;
        if (in_valid && in_start) begin
            nxt_state = in_end ? ST_SQUARE : ST_COLLECT;
        end else begin
            unique case (state)
                ST_IDLE:    nxt_state = ST_IDLE;
                ST_COLLECT: if (in_valid && in_end) nxt_state = ST_SQUARE;
                ST_SQUARE:  if (sq_idx == IW'(T_CORR)) nxt_state = ST_HOLD;
                ST_HOLD:    nxt_state = ST_HOLD;
                default:    nxt_state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           sq_idx <= IW'(1);
        else if (state != ST_SQUARE || first) sq_idx <= IW'(1);
        else                                  sq_idx <= sq_idx + IW'(1);
    end

    always_comb begin
        first = in_valid && in_start;
        beat  = first || (in_valid && state == ST_COLLECT);
        sq_en = (state == ST_SQUARE) && !first;
        done  = (state == ST_HOLD);
    end

    // R7: results stay presented until a valid start
    a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done && !(in_valid && in_start) |=> done);

    // R10: a valid start always withdraws the presented results
    a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_start |=> !done);

    // R6: results appear only after the squaring pass
    a_r6_done_after_square: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state == ST_SQUARE));

endmodule

// File: rtl/bchs_syndrome_calc.sv
module bchs_syndrome_calc
    import bchs_pkg::*;
#(
    parameter  int T_CORR = 12,
    parameter  int LANES  = 8,
    parameter  int LEN_W  = 17,
    localparam int NSYN   = 2 * T_CORR,
    localparam int GW     = 16,
    localparam int IW     = $clog2(T_CORR + 1),
    localparam int SW     = $clog2(NSYN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_start,
    input  logic               in_end,
    input  logic [LANES-1:0]   in_data,
    input  logic               wide_mode,
    input  logic               short_frame,
    input  logic [3:0]         rate_idx,
    output logic [NSYN*GW-1:0] synd_out,
    output logic               synd_done,
    output logic               synd_zero,
    output logic               len_match
);

    logic          beat, first, sq_en, done, len_ok;
    logic [IW-1:0] sq_idx;

    bchs_ctrl #(.T_CORR(T_CORR)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_start(in_start), .in_end(in_end),
        .beat(beat), .first(first), .sq_en(sq_en), .sq_idx(sq_idx), .done(done)
    );

    // configuration captured on the start beat
    logic       cfg_wide, cfg_short;
    logic [3:0] cfg_rate;
    logic       eff_wide, eff_short;
    logic [3:0] eff_rate;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_wide  <= 1'b0;
            cfg_short <= 1'b0;
            cfg_rate  <= '0;
        end else if (first) begin
            cfg_wide  <= wide_mode;
            cfg_short <= short_frame;
            cfg_rate  <= rate_idx;
        end
    end

    assign eff_wide  = first ? wide_mode   : cfg_wide;
    assign eff_short = first ? short_frame : cfg_short;
    assign eff_rate  = first ? rate_idx    : cfg_rate;

    logic [GW-1:0] odd_syn  [T_CORR];
    logic [GW-1:0] even_syn [T_CORR];
    logic [GW-1:0] all_syn  [NSYN];

    for (genvar i = 0; i < T_CORR; i++) begin : g_odd
        bchs_odd_acc #(.J(2 * i + 1), .LANES(LANES)) acc_i (
            .clk(clk), .rst_n(rst_n), .beat(beat), .first(first),
            .wide(eff_wide), .short_f(eff_short), .din(in_data), .syn(odd_syn[i])
        );
    end

    bchs_len_track #(.LANES(LANES), .CW(LEN_W)) len_i (
        .clk(clk), .rst_n(rst_n), .beat(beat), .first(first),
        .wide(eff_wide), .short_f(eff_short), .rate(eff_rate), .match(len_ok)
    );

    for (genvar j = 1; j <= NSYN; j++) begin : g_map
        if (j % 2 == 1) begin : g_o
            assign all_syn[j-1] = odd_syn[(j-1)/2];
        end else begin : g_e
            assign all_syn[j-1] = even_syn[j/2-1];
        end
        assign synd_out[GW*(j-1) +: GW] = all_syn[j-1];
    end

    // squaring pass: step i writes S_2i from S_i, ascending i
    logic [SW-1:0] src_idx;
    logic [GW-1:0] sq_src;

    assign src_idx = SW'(sq_idx) - SW'(1);
    assign sq_src  = all_syn[src_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < T_CORR; i++) even_syn[i] <= '0;
        end else if (first) begin
            for (int i = 0; i < T_CORR; i++) even_syn[i] <= '0;
        end else if (sq_en) begin
            even_syn[sq_idx - IW'(1)] <= gf_mul(sq_src, sq_src, cfg_short);
        end
    end

    logic any_set, upper_set;

    always_comb begin
        any_set   = 1'b0;
        upper_set = 1'b0;
        for (int j = 0; j < NSYN; j++) begin
            any_set   = any_set | (|all_syn[j]);
            upper_set = upper_set | (|all_syn[j][GW-1:14]);
        end
    end

    assign synd_done = done;
    assign synd_zero = done && !any_set;
    assign len_match = done && len_ok;

    // R8: the zero flag never appears without results
    a_r8_zero_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        synd_zero |-> synd_done);

    // R4: short-field results stay inside 14 bits
    a_r4_short_width: assert property (@(posedge clk) disable iff (!rst_n)
        synd_done && cfg_short |-> !upper_set);

    // R7: presented syndromes are frozen while held
    a_r7_out_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        synd_done && !(in_valid && in_start) |=> $stable(synd_out));

endmodule

// File: tb/bchs_syndrome_calc_tb.sv
module bchs_syndrome_calc_tb_top;

    localparam int NSYN = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0, in_start = 1'b0, in_end = 1'b0;
    logic [7:0]   in_data = '0;
    logic         wide_mode = 1'b0, short_frame = 1'b0;
    logic [3:0]   rate_idx = '0;
    logic [383:0] synd_out;
    logic         synd_done, synd_zero, len_match;

    int checks = 0;
    int errors = 0;

    logic        bits  [0:16199];
    logic [15:0] exp_s [1:NSYN];

    always #10 clk = ~clk;

    bchs_syndrome_calc dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_end(in_end), .in_data(in_data), .wide_mode(wide_mode),
        .short_frame(short_frame), .rate_idx(rate_idx), .synd_out(synd_out),
        .synd_done(synd_done), .synd_zero(synd_zero), .len_match(len_match)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // reference: carry-less product then reduction
    function automatic logic [15:0] ref_mul(input logic [15:0] a, input logic [15:0] b,
                                            input logic sh);
        logic [31:0] p, poly;
        int m;
        p = '0;
        for (int i = 0; i < 16; i++) if (b[i]) p = p ^ ({16'h0000, a} << i);
        m    = sh ? 14 : 16;
        poly = sh ? 32'h0000402B : 32'h0001002D;
        for (int d = 31; d >= m; d--) if (p[d]) p = p ^ (poly << (d - m));
        return p[15:0];
    endfunction

    task automatic model(input int n, input logic sh);
        logic [15:0] ap [1:NSYN];
        for (int j = 1; j <= NSYN; j++) begin
            ap[j] = 16'h0001;
            for (int e = 0; e < j; e++) ap[j] = ref_mul(ap[j], 16'h0002, sh);
            exp_s[j] = '0;
        end
        for (int b = 0; b < n; b++)
            for (int j = 1; j <= NSYN; j++)
                exp_s[j] = ref_mul(exp_s[j], ap[j], sh) ^ {15'h0000, bits[b]};
    endtask

    task automatic fill_lfsr(input int n, input logic [15:0] seed);
        logic [15:0] l = seed;
        for (int i = 0; i < n; i++) begin
            bits[i] = l[0];
            l = {l[0] ^ l[2] ^ l[3] ^ l[5], l[15:1]};
        end
    endtask

    task automatic fill_zero(input int n);
        for (int i = 0; i < n; i++) bits[i] = 1'b0;
    endtask

    // drives a frame from bits[]; returns at the negedge after the last beat
    task automatic drive_frame(input int n, input logic wide, input logic sh,
                               input logic [3:0] rate, input logic gaps,
                               input logic junk, input logic send_end);
        int beats = wide ? n / 8 : n;
        for (int b = 0; b < beats; b++) begin
            if (gaps && b != 0 && (b % 7) == 0) begin
                in_valid = 1'b0; in_start = 1'b1; in_end = 1'b1; in_data = 8'hFF;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_start = (b == 0);
            in_end   = send_end && (b == beats - 1);
            if (wide) begin
                for (int k = 0; k < 8; k++) in_data[7-k] = bits[8*b+k];
            end else begin
                in_data = {7'h7F, bits[b]};
            end
            if (b == 0 || !junk) begin
                wide_mode = wide; short_frame = sh; rate_idx = rate;
            end else begin
                wide_mode = ~wide; short_frame = ~sh; rate_idx = rate ^ 4'd5;
            end
            @(negedge clk);
        end
        in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0; in_data = 8'h00;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 40 && !synd_done; i++) @(negedge clk);
    endtask

    task automatic compare_syn(input string req);
        for (int j = 1; j <= NSYN; j++)
            check(req, $sformatf("S%0d", j), {16'h0, synd_out[16*(j-1) +: 16]}, {16'h0, exp_s[j]});
    endtask

    task automatic t_reset();
        check("R1", "done", {31'h0, synd_done}, 32'h0);
        check("R1", "zero", {31'h0, synd_zero}, 32'h0);
        check("R1", "len",  {31'h0, len_match}, 32'h0);
        check("R1", "synd", {31'h0, |synd_out}, 32'h0);
    endtask

    // narrow short frame, gaps with start asserted, config toggling mid frame
    task automatic t_serial_short();
        fill_lfsr(3240, 16'hACE1);
        model(3240, 1'b1);
        drive_frame(3240, 1'b0, 1'b1, 4'd0, 1'b1, 1'b1, 1'b1);
        repeat (11) @(negedge clk);
        check("R6", "done early", {31'h0, synd_done}, 32'h0);
        @(negedge clk);
        check("R6", "done on time", {31'h0, synd_done}, 32'h1);
        compare_syn("R2_R4_R5_R11");
        check("R9", "len short r0", {31'h0, len_match}, 32'h1);
        check("R8", "zero low", {31'h0, synd_zero}, 32'h0);
    endtask

    // valid beats without start while holding
    task automatic t_hold_ignored();
        for (int i = 0; i < 20; i++) begin
            in_valid = 1'b1; in_data = 8'hFF; in_end = (i == 10);
            @(negedge clk);
        end
        in_valid = 1'b0; in_end = 1'b0;
        @(negedge clk);
        check("R7", "done held", {31'h0, synd_done}, 32'h1);
        check("R9", "len held", {31'h0, len_match}, 32'h1);
        compare_syn("R7_R5");
    endtask

    task automatic t_wide_normal();
        fill_zero(16200);
        for (int i = 0; i < 60; i++) bits[(i * 271 + 13) % 16200] = 1'b1;
        bits[0] = 1'b1; bits[16199] = 1'b1;
        model(16200, 1'b0);
        drive_frame(16200, 1'b1, 1'b0, 4'd0, 1'b0, 1'b1, 1'b1);
        wait_done();
        check("R3", "done", {31'h0, synd_done}, 32'h1);
        compare_syn("R3_R4");
        check("R9", "len long r0", {31'h0, len_match}, 32'h1);
    endtask

    task automatic t_zero();
        fill_zero(96);
        drive_frame(96, 1'b0, 1'b1, 4'd3, 1'b0, 1'b0, 1'b1);
        wait_done();
        check("R8", "zero flag", {31'h0, synd_zero}, 32'h1);
        check("R9", "len mismatch", {31'h0, len_match}, 32'h0);
        check("R8", "synd all zero", {31'h0, |synd_out}, 32'h0);
    endtask

    task automatic t_restart();
        // partial frame abandoned mid collection
        fill_lfsr(40, 16'h1234);
        drive_frame(40, 1'b0, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0);
        check("R10", "no done mid frame", {31'h0, synd_done}, 32'h0);
        fill_lfsr(200, 16'h5A5A);
        model(200, 1'b0);
        drive_frame(200, 1'b1, 1'b0, 4'd4, 1'b0, 1'b0, 1'b1);
        wait_done();
        compare_syn("R10_collect");
        // restart during the squaring pass
        fill_lfsr(64, 16'h0F0F);
        drive_frame(64, 1'b1, 1'b0, 4'd1, 1'b0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        fill_lfsr(128, 16'hBEEF);
        model(128, 1'b1);
        drive_frame(128, 1'b0, 1'b1, 4'd6, 1'b0, 1'b0, 1'b1);
        wait_done();
        compare_syn("R10_square");
    endtask

    task automatic t_single();
        for (int k = 0; k < 8; k++) bits[k] = k[0] ? 1'b0 : 1'b1;
        bits[5] = 1'b1;
        model(8, 1'b0);
        drive_frame(8, 1'b1, 1'b0, 4'd9, 1'b0, 1'b0, 1'b1);
        wait_done();
        check("R12", "done", {31'h0, synd_done}, 32'h1);
        compare_syn("R12");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_serial_short();
        t_hold_ignored();
        t_wide_normal();
        t_zero();
        t_restart();
        t_single();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule